// File: doc/BRIEF.md
# Multi-Mode Floating-Point Min/Max Unit

This combinational unit takes two 64-bit binary64 operands and a 4-bit mode code, and returns either the smaller or the larger of the two. Sixteen mode codes come from one shared datapath. Each code combines three choices:

- minimum or maximum;
- a plain signed comparison, or one that compares magnitudes first;
- one of four rules for handling NaN inputs.

The unit also reports whether a signaling NaN was seen. It produces a write enable for the result, which drops when such an input meets an enabled trap. When record mode is on, it produces a 4-bit condition summary.

An execution stage uses the unit by driving both operands and the mode in the same cycle, then reading the outputs after the combinational delay. The unit holds no state and has no clock. Rounding, register-file access and the trap mechanism itself belong to the surrounding pipeline.

Top module: `fp_minmax_core`

## Requirements
- R1: `mode_i` is read as {is_max, by_magnitude, rule[1:0]}, with mode_i[3] set meaning maximum. When neither operand is NaN, operands are ordered as sign-magnitude values: any negative operand lies below any non-negative one, and between two negatives the larger magnitude is the smaller value. Min returns the lower operand, max the higher, and when the comparison finds neither lower it returns B.
- R2: -0.0 orders below +0.0 in the plain comparison. min(+0,-0) and min(-0,+0) both return -0, and max(-0,+0) returns +0.
- R3: With mode_i[2] set and operand magnitudes that differ, min returns the operand with the smaller magnitude and max the one with the larger, whatever the signs.
- R4: With mode_i[2] set and equal magnitudes, the result is that of the plain signed comparison of the same rule. For example, min-magnitude(1,-1) gives -1 and max-magnitude(-1,1) gives 1.
- R5: With rule 2'b11 and mode_i[2] set, a zero of either sign is compared as plain zero, so two zeros tie and B is returned. With mode_i[2] clear, rule 2'b11 keeps the signed-zero order of R2.
- R6: Rule 2'b00 with any NaN input chooses its result in this order: A quieted if A is signaling; else B quieted if B is signaling; else A quieted if both are NaN; else the operand that is not NaN, unchanged.
- R7: Rule 2'b01 with any NaN input returns A quieted if A is NaN, else B quieted.
- R8: Rule 2'b10 returns A quieted when both inputs are NaN, and the non-NaN operand unchanged when only one input is NaN.
- R9: Rule 2'b11 with any NaN input returns B unchanged.
- R10: An operand is NaN when its value with the sign cleared is unsigned-greater than 0x7FF0000000000000. It is signaling when bit 51 (the top fraction bit, LSB-0 numbering) is clear. Quieting sets bit 51. Infinity is an ordinary number.
- R11: `snan_flag_o` is high exactly when at least one operand is a signaling NaN.
- R12: `wr_en_o` is low only when a signaling NaN is present and `trap_en_i` is high, and is high otherwise.
- R13: When `rec_en_i` is high, `cond_o` is {summary exception, enabled exception, invalid, overflow}, MSB first. Summary and invalid equal the signaling-NaN flag, enabled exception is that flag ANDed with `trap_en_i`, and overflow is 0. When `rec_en_i` is low, `cond_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a_i | input | 64 | Operand A, binary64 |
| op_b_i | input | 64 | Operand B, binary64 |
| mode_i | input | 4 | {is_max, by_magnitude, nan rule[1:0]} |
| trap_en_i | input | 1 | Invalid-operation trap enable |
| rec_en_i | input | 1 | Record enable for the condition summary |
| res_o | output | 64 | Selected minimum or maximum |
| wr_en_o | output | 1 | Result may be written back |
| snan_flag_o | output | 1 | Signaling NaN seen on an input |
| cond_o | output | 4 | Condition summary, zero when not recording |

## Verification
The bench aims at the zero and NaN corners, where a plausible design goes wrong without being noticed:

- **Signed zeros.** A sign-blind comparison returns +0 where -0 is owed.
- **Magnitude mode under the ternary rule.** A unit that forgets to flatten zeros returns A instead of B.
- **Equal magnitudes.** A unit without the magnitude fallback picks the wrong sign.
- **NaN payloads.** Each rule is driven with signaling, quiet and sign-set NaNs in both positions. A wrong priority or a missing quiet bit shows up as the wrong payload.
- **Infinity.** It must not be classed as NaN.
- **Trap and record outputs.** The write enable and condition bits are checked with the trap and record inputs on and off, to catch a dropped gate.

// File: rtl/fpmm_pkg.sv
package fpmm_pkg;
  localparam int unsigned FP_W      = 64;
  localparam int unsigned FP_EXP_W  = 11;
  localparam int unsigned FP_FRAC_W = FP_W - 1 - FP_EXP_W;
  localparam int unsigned QBIT      = FP_FRAC_W - 1;
  localparam int unsigned MODE_W    = 4;
  localparam int unsigned COND_W    = 4;

  typedef logic [FP_W-1:0] fp_t;

  localparam fp_t INF_MAG = {1'b0, {FP_EXP_W{1'b1}}, {FP_FRAC_W{1'b0}}};

  typedef enum logic [1:0] {
    RULE_NUM08 = 2'b00,
    RULE_MIN19 = 2'b01,
    RULE_NUM19 = 2'b10,
    RULE_TERN  = 2'b11
  } nan_rule_e;

  typedef struct packed {
    logic      is_max;
    logic      by_mag;
    nan_rule_e rule;
  } mode_t;

  typedef struct packed {
    logic nan;
    logic snan;
    fp_t  quieted;
    fp_t  mag;
  } fp_class_t;

  function automatic fp_t mag_of(fp_t x);
    return {1'b0, x[FP_W-2:0]};
  endfunction

  function automatic logic is_nan(fp_t x);
    return mag_of(x) > INF_MAG;
  endfunction

  function automatic fp_t quiet(fp_t x);
    fp_t q;
    q = x;
    q[QBIT] = 1'b1;
    return q;
  endfunction

  // Sign-magnitude strict less-than on raw encodings.
  function automatic logic sm_less(fp_t l, fp_t r);
    if (l[FP_W-1]) begin
      if (!r[FP_W-1]) return 1'b1;
      return l > r;
    end
    if (r[FP_W-1]) return 1'b0;
    return l < r;
  endfunction
endpackage

// File: rtl/fpmm_classify.sv
module fpmm_classify
  import fpmm_pkg::*;
(
  input  fp_t       op_i,
  output fp_class_t cls_o
);
  always_comb begin
    cls_o.mag     = mag_of(op_i);
    cls_o.nan     = is_nan(op_i);
    cls_o.snan    = cls_o.nan && !op_i[QBIT];
    cls_o.quieted = quiet(op_i);
  end

  always_comb begin
    // R10
    quiet_keeps_nan_chk: assert (!cls_o.nan || is_nan(cls_o.quieted))
      else $error("quieting lost NaN");
  end
endmodule

// File: rtl/fpmm_order.sv
module fpmm_order
  import fpmm_pkg::*;
(
  input  fp_t   a_i,
  input  fp_t   b_i,
  input  fp_t   mag_a_i,
  input  fp_t   mag_b_i,
  input  mode_t mode_i,
  output logic  pick_a_o
);
  fp_t cmp_l, cmp_r, lhs, rhs;
  logic mag_differ;

  assign mag_differ = (mag_a_i != mag_b_i);

  always_comb begin
    cmp_l = a_i;
    cmp_r = b_i;
    if (mode_i.by_mag && mag_differ) begin
      cmp_l = mag_a_i;
      cmp_r = mag_b_i;
    end
    if (mode_i.by_mag && mode_i.rule == RULE_TERN) begin
      if (mag_a_i == '0) cmp_l = '0;
      if (mag_b_i == '0) cmp_r = '0;
    end
    lhs = mode_i.is_max ? cmp_r : cmp_l;
    rhs = mode_i.is_max ? cmp_l : cmp_r;
    pick_a_o = sm_less(lhs, rhs);
  end

  always_comb begin
    // R3
    mag_min_pick_chk: assert (!(mode_i.by_mag && !mode_i.is_max && (mag_a_i < mag_b_i)) || pick_a_o)
      else $error("magnitude min did not pick smaller magnitude");
  end
endmodule

// File: rtl/fpmm_nan_sel.sv
module fpmm_nan_sel
  import fpmm_pkg::*;
(
  input  nan_rule_e rule_i,
  input  fp_t       a_i,
  input  fp_t       b_i,
  input  fp_t       qa_i,
  input  fp_t       qb_i,
  input  logic      a_nan_i,
  input  logic      b_nan_i,
  input  logic      a_snan_i,
  input  logic      b_snan_i,
  output fp_t       nan_res_o
);
  always_comb begin
    unique case (rule_i)
      RULE_NUM08: begin
        if (a_snan_i)                nan_res_o = qa_i;
        else if (b_snan_i)           nan_res_o = qb_i;
        else if (a_nan_i && b_nan_i) nan_res_o = qa_i;
        else if (a_nan_i)            nan_res_o = b_i;
        else                         nan_res_o = a_i;
      end
      RULE_MIN19: nan_res_o = a_nan_i ? qa_i : qb_i;
      RULE_NUM19: begin
        if (a_nan_i && b_nan_i) nan_res_o = qa_i;
        else if (a_nan_i)       nan_res_o = b_i;
        else                    nan_res_o = a_i;
      end
      default: nan_res_o = b_i;
    endcase
  end

  always_comb begin
    // R7
    min19_quiet_nan_chk: assert (!(rule_i == RULE_MIN19 && (a_nan_i || b_nan_i))
                                 || (is_nan(nan_res_o) && nan_res_o[QBIT]))
      else $error("rule 01 did not give a quiet NaN");
  end
endmodule

// File: rtl/fp_minmax_core.sv
module fp_minmax_core
  import fpmm_pkg::*;
(
  input  logic [FP_W-1:0]   op_a_i,
  input  logic [FP_W-1:0]   op_b_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              trap_en_i,
  input  logic              rec_en_i,
  output logic [FP_W-1:0]   res_o,
  output logic              wr_en_o,
  output logic              snan_flag_o,
  output logic [COND_W-1:0] cond_o
);
  localparam int unsigned N_OPS = 2;

  mode_t     mode;
  fp_t       ops [N_OPS];
  fp_class_t cls [N_OPS];
  fp_t       nan_res;
  logic      pick_a, any_nan, any_snan, trap_hit;

  assign mode   = mode_t'(mode_i);
  assign ops[0] = op_a_i;
  assign ops[1] = op_b_i;

  for (genvar gi = 0; gi < N_OPS; gi++) begin : g_cls
    fpmm_classify u_cls (.op_i(ops[gi]), .cls_o(cls[gi]));
  end

  fpmm_order u_order (
    .a_i(op_a_i), .b_i(op_b_i),
    .mag_a_i(cls[0].mag), .mag_b_i(cls[1].mag),
    .mode_i(mode), .pick_a_o(pick_a)
  );

  fpmm_nan_sel u_nan (
    .rule_i(mode.rule), .a_i(op_a_i), .b_i(op_b_i),
    .qa_i(cls[0].quieted), .qb_i(cls[1].quieted),
    .a_nan_i(cls[0].nan), .b_nan_i(cls[1].nan),
    .a_snan_i(cls[0].snan), .b_snan_i(cls[1].snan),
    .nan_res_o(nan_res)
  );

  assign any_nan     = cls[0].nan || cls[1].nan;
  assign any_snan    = cls[0].snan || cls[1].snan;
  assign trap_hit    = any_snan && trap_en_i;
  assign res_o       = any_nan ? nan_res : (pick_a ? op_a_i : op_b_i);
  assign snan_flag_o = any_snan;
  assign wr_en_o     = !trap_hit;
  assign cond_o      = rec_en_i ? {any_snan, trap_hit, any_snan, 1'b0} : '0;

  always_comb begin
    // R1
    number_pick_chk: assert (any_nan || res_o == op_a_i || res_o == op_b_i)
      else $error("numeric result is neither operand");
    // R9
    tern_nan_b_chk: assert (!(mode.rule == RULE_TERN && any_nan) || res_o == op_b_i)
      else $error("rule 11 NaN result is not B");
    // R11
    snan_needs_nan_chk: assert (!snan_flag_o || any_nan)
      else $error("signaling flag without NaN input");
    // R12
    wr_block_chk: assert (wr_en_o || (snan_flag_o && trap_en_i))
      else $error("write blocked without trap");
    // R13
    cond_quiet_chk: assert (rec_en_i || cond_o == '0)
      else $error("condition bits set while not recording");
  end
endmodule

// File: tb/fp_minmax_core_tb.sv
module fp_minmax_core_tb_top;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  logic [63:0] a, b, res;
  logic [3:0]  mode, cond;
  logic        trap, rec, wr, flag;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  localparam logic [63:0] P1 = 64'h3FF0000000000000, P2 = 64'h4000000000000000,
    N1 = 64'hBFF0000000000000, N2 = 64'hC000000000000000,
    PZ = 64'h0, NZ = 64'h8000000000000000, INF = 64'h7FF0000000000000,
    QN = 64'h7FF8000000000000, SN = 64'h7FF4000000000000,
    SNQ = 64'h7FFC000000000000, QN2 = 64'hFFF8000000000001;

  fp_minmax_core dut_i (
    .op_a_i(a), .op_b_i(b), .mode_i(mode), .trap_en_i(trap), .rec_en_i(rec),
    .res_o(res), .wr_en_o(wr), .snan_flag_o(flag), .cond_o(cond)
  );

  task automatic drive(input logic [63:0] xa, xb, input logic [3:0] m,
                       input logic tr = 1'b0, input logic rc = 1'b0);
    @(negedge clk);
    a = xa; b = xb; mode = m; trap = tr; rec = rc;
    #(CLK_P/4);
  endtask

  task automatic chk(input string tag, input logic [63:0] act, exp_v);
    n_chk++;
    if (act !== exp_v) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp_v);
    end
  endtask

  task automatic t_idle;
    drive(PZ, PZ, 4'b0000);
    chk("idle R1 res", res, PZ);
    chk("idle R12 wr", {63'd0, wr}, 64'd1);
    chk("idle R11 flag", {63'd0, flag}, 64'd0);
    chk("idle R13 cond", {60'd0, cond}, 64'd0);
  endtask

  task automatic t_plain;
    drive(P1, P2, 4'b0000); chk("R1 min(1,2)", res, P1);
    drive(P1, P2, 4'b1000); chk("R1 max(1,2)", res, P2);
    drive(N1, P2, 4'b0000); chk("R1 min(-1,2)", res, N1);
    drive(N2, N1, 4'b1001); chk("R1 max(-2,-1)", res, N1);
    drive(N2, N1, 4'b0001); chk("R1 min(-2,-1)", res, N2);
  endtask

  task automatic t_zero;
    drive(PZ, NZ, 4'b0000); chk("R2 min(+0,-0)", res, NZ);
    drive(NZ, PZ, 4'b0000); chk("R2 min(-0,+0)", res, NZ);
    drive(NZ, PZ, 4'b1000); chk("R2 max(-0,+0)", res, PZ);
  endtask

  task automatic t_mag;
    drive(N1, P2, 4'b0100); chk("R3 minmag(-1,2)", res, N1);
    drive(N2, P1, 4'b1100); chk("R3 maxmag(-2,1)", res, N2);
    drive(P2, N1, 4'b0100); chk("R3 minmag(2,-1)", res, N1);
    drive(P1, N1, 4'b0100); chk("R4 minmag(1,-1)", res, N1);
    drive(N1, P1, 4'b1100); chk("R4 maxmag(-1,1)", res, P1);
  endtask

  task automatic t_tern_zero;
    drive(NZ, PZ, 4'b0111); chk("R5 tern minmag(-0,+0)", res, PZ);
    drive(PZ, NZ, 4'b1111); chk("R5 tern maxmag(+0,-0)", res, NZ);
    drive(NZ, PZ, 4'b0011); chk("R5 tern min(-0,+0)", res, NZ);
  endtask

  task automatic t_rule00;
    drive(SN, P1, 4'b0000);  chk("R6 (sn,1)", res, SNQ);
    drive(P1, SN, 4'b0000);  chk("R6 (1,sn)", res, SNQ);
    drive(QN, SN, 4'b0000);  chk("R6 (qn,sn)", res, SNQ);
    drive(QN, P1, 4'b0000);  chk("R6 (qn,1)", res, P1);
    drive(P1, QN2, 4'b0000); chk("R6 (1,qn2)", res, P1);
    drive(QN2, QN, 4'b0000); chk("R6 (qn2,qn)", res, QN2);
    drive(QN, P2, 4'b1000);  chk("R6 max(qn,2)", res, P2);
  endtask

  task automatic t_rule01;
    drive(P1, QN, 4'b0001);  chk("R7 (1,qn)", res, QN);
    drive(SN, P1, 4'b0001);  chk("R7 (sn,1)", res, SNQ);
    drive(QN2, SN, 4'b1001); chk("R7 (qn2,sn)", res, QN2);
  endtask

  task automatic t_rule10;
    drive(QN, P1, 4'b0010);  chk("R8 (qn,1)", res, P1);
    drive(SN, P2, 4'b0010);  chk("R8 (sn,2)", res, P2);
    drive(SN, QN2, 4'b0010); chk("R8 (sn,qn2)", res, SNQ);
  endtask

  task automatic t_rule11;
    drive(QN, P1, 4'b0011); chk("R9 (qn,1)", res, P1);
    drive(P1, QN, 4'b1011); chk("R9 (1,qn)", res, QN);
    drive(P1, SN, 4'b0011); chk("R9 (1,sn)", res, SN);
  endtask

  task automatic t_classify;
    drive(INF, P1, 4'b0010); chk("R10 inf min", res, P1);
    chk("R10 inf not snan", {63'd0, flag}, 64'd0);
    drive(INF, P2, 4'b1010); chk("R10 inf max", res, INF);
  endtask

  task automatic t_flags;
    drive(QN, P1, 4'b0000, 1'b1, 1'b1);
    chk("R11 quiet no flag", {63'd0, flag}, 64'd0);
    chk("R12 quiet trap wr", {63'd0, wr}, 64'd1);
    chk("R13 quiet cond", {60'd0, cond}, 64'd0);
    drive(SN, P1, 4'b0000, 1'b1, 1'b1);
    chk("R11 sn a flag", {63'd0, flag}, 64'd1);
    chk("R12 sn trap wr", {63'd0, wr}, 64'd0);
    chk("R13 sn trap cond", {60'd0, cond}, 64'hE);
    drive(P1, SN, 4'b0000, 1'b0, 1'b1);
    chk("R11 sn b flag", {63'd0, flag}, 64'd1);
    chk("R12 sn notrap wr", {63'd0, wr}, 64'd1);
    chk("R13 sn notrap cond", {60'd0, cond}, 64'hA);
    drive(SN, P1, 4'b0000, 1'b1, 1'b0);
    chk("R13 rec off cond", {60'd0, cond}, 64'd0);
    drive(P1, P2, 4'b0000, 1'b1, 1'b1);
    chk("R13 number cond", {60'd0, cond}, 64'd0);
  endtask

  initial begin
    a = '0; b = '0; mode = '0; trap = 1'b0; rec = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    t_idle; t_plain; t_zero; t_mag; t_tern_zero;
    t_rule00; t_rule01; t_rule10; t_rule11; t_classify; t_flags;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule